// File: doc/BRIEF.md
# Register Write Guard with Two-Key Unlock

This block sits in front of a peripheral's register file and decides, write by write, whether a bus write may reach it. It watches a plain write bus (address, data, strobe). A configurable address window is protected. While the guard is locked, writes into that window are held back and recorded in a sticky error flag. Writes outside the window always pass.

To open the guard, software writes two fixed 32-bit magic values in order: the first to one key address, then the second to another key address. Any other value written to the first key address closes the guard again at once. The key addresses read as zero. A status word reports whether the guard is open and whether a write has been dropped. Writes to the key and status addresses are consumed by the guard and never forwarded.

Top module: `reg_write_guard`

## Requirements
- R1: After reset the guard is locked (`unlocked` = 0), the error flag is clear (`wr_err` = 0) and no first key is pending.
- R2: A write of 0x83E70B13 to address 0x6C, followed by a write of 0x95A4F1E0 to address 0x70, raises `unlocked` in the cycle after the second write.
- R3: A correct second key opens the guard only if the immediately preceding key-address write (to 0x6C or 0x70) was a correct first key. A wrong first key, a wrong second key, or a second key with no first key in front of it leaves the guard locked and forces a fresh start.
- R4: A write of any value other than 0x83E70B13 to address 0x6C, zero included, clears `unlocked` in the next cycle.
- R5: Writes to addresses other than 0x6C and 0x70 do not disturb a pending first key.
- R6: `wr_pass` follows `wr_en` in the same cycle for addresses outside the protected window (default 0x00 to 0x5F). For addresses inside it, `wr_pass` does so only while `unlocked` is 1.
- R7: A write dropped under R6 sets `wr_err` in the next cycle. The flag stays set until a write to the status address 0x74 with data bit 1 = 1.
- R8: A read (`rd_en`) returns its data on `rd_data` with `rd_valid` one cycle later. Addresses 0x6C and 0x70 read as 0. Address 0x74 reads bit 0 = unlocked and bit 1 = error flag, with the other bits 0. Any other address reads 0.
- R9: Writes to 0x6C, 0x70 and 0x74 never raise `wr_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data valid |
| wr_pass | output | 1 | Qualified write strobe for the register file |
| unlocked | output | 1 | Guard open |
| wr_err | output | 1 | Sticky dropped-write flag |

## Verification
`wr_pass` is combinational, so the bench samples it one time unit after driving a write, inside the same cycle. `unlocked` and `wr_err` are registered and change at the first rising edge after the write, so the bench samples them at the following falling edge. Read data trails `rd_en` by exactly one edge. The driver queues each expected read word as it issues the read, and a monitor pops the queue whenever `rd_valid` is seen at a falling edge. A missing or extra response therefore shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/reg_write_guard.sv
module reg_write_guard #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  KEY0_ADDR = 8'h6C,
  parameter logic [7:0]  KEY1_ADDR = 8'h70,
  parameter logic [7:0]  STAT_ADDR = 8'h74,
  parameter logic [7:0]  PROT_LO   = 8'h00,
  parameter logic [7:0]  PROT_HI   = 8'h5F,
  parameter logic [31:0] KEY0_VAL  = 32'h83E70B13,
  parameter logic [31:0] KEY1_VAL  = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              wr_pass,
  output logic              unlocked,
  output logic              wr_err
);
  localparam logic [ADDR_W-1:0] K0A = ADDR_W'(KEY0_ADDR);
  localparam logic [ADDR_W-1:0] K1A = ADDR_W'(KEY1_ADDR);
  localparam logic [ADDR_W-1:0] STA = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] PLO = ADDR_W'(PROT_LO);
  localparam logic [ADDR_W-1:0] PHI = ADDR_W'(PROT_HI);

  logic armed;
  logic hit_k0, hit_k1, hit_st, own, prot, drop;

  assign hit_k0 = wr_en && (wr_addr == K0A);
  assign hit_k1 = wr_en && (wr_addr == K1A);
  assign hit_st = wr_en && (wr_addr == STA);
  assign own    = (wr_addr == K0A) || (wr_addr == K1A) || (wr_addr == STA);
  assign prot   = (wr_addr >= PLO) && (wr_addr <= PHI);
  assign drop   = wr_en && !own && prot && !unlocked;
  assign wr_pass = wr_en && !own && (!prot || unlocked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      unlocked <= 1'b0;
    end else if (hit_k0) begin
      armed <= (wr_data == KEY0_VAL);
      if (wr_data != KEY0_VAL) unlocked <= 1'b0;
    end else if (hit_k1) begin
      armed <= 1'b0;
      if (armed && wr_data == KEY1_VAL) unlocked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   wr_err <= 1'b0;
    else if (drop)                wr_err <= 1'b1;
    else if (hit_st && wr_data[1]) wr_err <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= (rd_addr == STA) ? {30'd0, wr_err, unlocked} : 32'd0;
    end
  end
endmodule

// File: rtl/reg_write_guard_chk.sv
module reg_write_guard_chk #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  KEY0_ADDR = 8'h6C,
  parameter logic [7:0]  KEY1_ADDR = 8'h70,
  parameter logic [7:0]  PROT_LO   = 8'h00,
  parameter logic [7:0]  PROT_HI   = 8'h5F,
  parameter logic [31:0] KEY0_VAL  = 32'h83E70B13,
  parameter logic [31:0] KEY1_VAL  = 32'h95A4F1E0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              wr_pass,
  input logic              unlocked,
  input logic              wr_err,
  input logic              armed
);
  logic k0w, k1w, inprot;
  assign k0w    = wr_en && wr_addr == ADDR_W'(KEY0_ADDR);
  assign k1w    = wr_en && wr_addr == ADDR_W'(KEY1_ADDR);
  assign inprot = wr_addr >= ADDR_W'(PROT_LO) && wr_addr <= ADDR_W'(PROT_HI);

  // R2
  open_on_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k1w && armed && wr_data == KEY1_VAL) |=> unlocked);
  // R3
  no_open_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k1w && !armed && !unlocked) |=> !unlocked);
  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k0w && wr_data != KEY0_VAL) |=> !unlocked);
  // R6
  block_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inprot && !unlocked) |-> !wr_pass);
  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inprot && !unlocked) |=> wr_err);
  // R8
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R9
  key_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k0w || k1w) |-> !wr_pass);
endmodule

bind reg_write_guard reg_write_guard_chk #(
  .ADDR_W(ADDR_W), .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR),
  .PROT_LO(PROT_LO), .PROT_HI(PROT_HI), .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_valid(rd_valid), .wr_pass(wr_pass), .unlocked(unlocked),
  .wr_err(wr_err), .armed(armed)
);

// File: tb/reg_write_guard_test.sv
module reg_write_guard_test;
  localparam logic [31:0] K0 = 32'h83E70B13;
  localparam logic [31:0] K1 = 32'h95A4F1E0;
  localparam logic [7:0]  A0 = 8'h6C, A1 = 8'h70, AS = 8'h74;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic rd_valid, wr_pass, unlocked, wr_err;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  reg_write_guard uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .wr_pass(wr_pass), .unlocked(unlocked), .wr_err(wr_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit exp_pass, input string req);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    #1 chk(wr_pass === exp_pass, req, 32'(wr_pass), 32'(exp_pass));
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic state(input bit u, input bit e, input string req);
    chk(unlocked === u, {req, " unlocked"}, 32'(unlocked), 32'(u));
    chk(wr_err === e, {req, " wr_err"}, 32'(wr_err), 32'(e));
  endtask

  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_q.size() == 0) chk(0, "R8 unexpected rd_valid", rd_data, 0);
    else begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(rd_data === e, t, rd_data, e);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    state(0, 0, "R1");
    rd(AS, 32'd0, "R1 status after reset");
    wr(8'h10, 32'hAAAA, 0, "R6 locked protected");
    state(0, 1, "R7 set");
    rd(AS, 32'd2, "R8 status err");
    wr(AS, 32'd2, 0, "R9 status write");
    state(0, 0, "R7 clear");
    wr(8'h80, 32'h1, 1, "R6 unprotected");
    state(0, 0, "R6 no err");
    wr(A1, K1, 0, "R9 key1");
    state(0, 0, "R3 key1 alone");
    wr(A0, K0, 0, "R9 key0");
    wr(8'h90, 32'h5, 1, "R5 other write");
    wr(A1, K1, 0, "R9 key1");
    state(1, 0, "R2 R5 unlock");
    rd(A0, 32'd0, "R8 key0 reads 0");
    rd(A1, 32'd0, "R8 key1 reads 0");
    rd(AS, 32'd1, "R8 status open");
    wr(8'h10, 32'h7, 1, "R6 unlocked protected");
    wr(A0, 32'd0, 0, "R9 key0");
    state(0, 0, "R4 zero relock");
    wr(A0, K0, 0, "R9"); wr(A0, 32'h1234, 0, "R9"); wr(A1, K1, 0, "R9");
    state(0, 0, "R3 wrong key0");
    wr(A0, K0, 0, "R9"); wr(A1, 32'h5, 0, "R9"); wr(A1, K1, 0, "R9");
    state(0, 0, "R3 wrong key1");
    wr(A0, K0, 0, "R9"); wr(A1, K1, 0, "R9");
    state(1, 0, "R2 reopen");
    wr(A0, 32'hFFFFFFFF, 0, "R9");
    state(0, 0, "R4 other relock");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 missing responses", exp_q.size(), 0);
    finish_run();
  end
endmodule